// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings so that a lookup can skip the page table in memory. A 14-bit virtual address is split into a page offset, a set index and a tag. The tag is compared against every way of the indexed set at once. On a match, the physical page number is joined with the unchanged offset to form a 12-bit physical address in the same cycle as the request. On no match the block raises a miss flag. An external table walker then returns the mapping through the fill port.

Entries are placed in an empty way when one exists. In a full set they go to the way named by a round-robin pointer kept for that set. A flush input, used on a context switch, drops every mapping that is not marked global. A fill that arrives in the same cycle as a flush is discarded.

Top module: `vpn_xlate_tlb`

## Requirements
- R1: After reset every entry is invalid and every lookup reports a miss.
- R2: The address fields are fixed as follows. Offset is VA[5:0], set index is VA[7:6] (the low two bits of the page number), and tag is VA[13:8]. A hit needs a valid entry with an equal tag in the indexed set, so the same tag stored in a different set does not match.
- R3: On a hit, `lk_hit` is 1, `lk_miss` is 0 and `lk_pa` is {stored PPN, VA[5:0]}, all in the same cycle as the request. For example, VA 0x03D4 mapped to PPN 0x0D gives PA 0x354.
- R4: With `lk_req` high and no match, `lk_miss` is 1 and `lk_pa` is 0. With `lk_req` low, `lk_hit`, `lk_miss` and `lk_pa` are all 0.
- R5: A fill stores the page number `fill_vpn` (set = fill_vpn[1:0], tag = fill_vpn[7:2]) with `fill_ppn` and `fill_global`. Lookups see the new entry from the next cycle on.
- R6: A fill whose page number is already present in its set overwrites that way in place. The other ways of the set are kept.
- R7: A fill of a new page number takes the lowest-numbered invalid way of its set. If the set is full, it takes the way named by that set's pointer. The pointer is 0 after reset and advances by one, modulo 4, only after such a replacement.
- R8: A flush invalidates every entry whose global flag is 0. Global entries stay valid and keep hitting.
- R9: When `flush` and `fill_en` are high in the same cycle, only the flush takes effect. The fill writes nothing and moves no pointer.
- R10: Repeating a lookup with no fill or flush in between returns the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request made, no translation held |
| lk_pa | output | 12 | Physical address on a hit, else 0 |
| fill_en | input | 1 | Write a mapping from the walker |
| fill_vpn | input | 8 | Virtual page number of the mapping |
| fill_ppn | input | 6 | Physical page number of the mapping |
| fill_global | input | 1 | Mapping survives a flush |
| flush | input | 1 | Context-switch invalidation of non-global entries |

## Verification
The hardest state to reach is a full set whose round-robin pointer has wrapped, combined with a mix of global and non-global entries that a flush then thins out. After the flush, new fills must land in the freed holes before the pointer is used again. Directed sequences fill one set past capacity, refill a present page, flush with a global survivor, and collide a fill with a flush. A long seeded random run then draws page numbers from a narrow tag range. This forces repeated replacement in every set and interleaves rare flushes, and each cycle is checked against a bench reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W  = 14;
    parameter int OFF_W = 6;
    parameter int PPN_W = 6;
    parameter int SET_N = 4;
    parameter int WAY_N = 4;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int SET_W = $clog2(SET_N);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAY_N);
    localparam int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef tlb_entry_t [WAY_N-1:0] tlb_set_t;

    typedef struct packed {
        tlb_set_t [SET_N-1:0]             sets;
        logic     [SET_N-1:0][WAY_W-1:0]  rr;
    } tlb_state_t;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
(
    input  tlb_set_t          set_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [WAY_N-1:0]  match_o,
    output logic [PPN_W-1:0]  ppn_o
);
    // Parallel tag compare across all ways of one set
    for (genvar w = 0; w < WAY_N; w++) begin : g_cmp
        assign match_o[w] = set_i[w].valid && (set_i[w].tag == tag_i);
    end

    // At most one way matches, so an OR of gated PPNs selects it
    always_comb begin
        ppn_o = '0;
        for (int w = 0; w < WAY_N; w++) begin
            if (match_o[w]) ppn_o = ppn_o | set_i[w].ppn;
        end
    end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlb_pkg::*;
(
    input  tlb_set_t          set_i,
    input  logic [WAY_N-1:0]  match_i,
    input  logic [WAY_W-1:0]  rr_i,
    output logic [WAY_W-1:0]  way_o,
    output logic              advance_o
);
    logic found;

    always_comb begin
        way_o     = rr_i;
        advance_o = 1'b1;
        found     = 1'b0;
        // First choice: lowest empty way
        for (int w = 0; w < WAY_N; w++) begin
            if (!found && !set_i[w].valid) begin
                way_o     = WAY_W'(w);
                advance_o = 1'b0;
                found     = 1'b1;
            end
        end
        // A page already held is rewritten where it sits
        if (|match_i) begin
            advance_o = 1'b0;
            for (int w = 0; w < WAY_N; w++) begin
                if (match_i[w]) way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/vpn_xlate_tlb.sv
module vpn_xlate_tlb
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_pa,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_global,
    input  logic             flush
);
    tlb_state_t st_q, st_d;

    // Lookup path
    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [WAY_N-1:0] lk_match;
    logic [PPN_W-1:0] lk_ppn;

    assign lk_set = lk_va[OFF_W +: SET_W];
    assign lk_tag = lk_va[VA_W-1 -: TAG_W];

    tlb_way_match u_lk_match (
        .set_i   (st_q.sets[lk_set]),
        .tag_i   (lk_tag),
        .match_o (lk_match),
        .ppn_o   (lk_ppn)
    );

    assign lk_hit  = lk_req && (|lk_match);
    assign lk_miss = lk_req && !(|lk_match);
    assign lk_pa   = lk_hit ? {lk_ppn, lk_va[OFF_W-1:0]} : '0;

    // Fill path
    logic [SET_W-1:0] f_set;
    logic [TAG_W-1:0] f_tag;
    logic [WAY_N-1:0] f_match;
    logic [PPN_W-1:0] f_ppn_unused;
    logic [WAY_W-1:0] f_way;
    logic             f_adv;

    assign f_set = fill_vpn[SET_W-1:0];
    assign f_tag = fill_vpn[VPN_W-1:SET_W];

    tlb_way_match u_fill_match (
        .set_i   (st_q.sets[f_set]),
        .tag_i   (f_tag),
        .match_o (f_match),
        .ppn_o   (f_ppn_unused)
    );

    tlb_victim_sel u_victim (
        .set_i     (st_q.sets[f_set]),
        .match_i   (f_match),
        .rr_i      (st_q.rr[f_set]),
        .way_o     (f_way),
        .advance_o (f_adv)
    );

    // Next-state process: flush outranks fill
    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int s = 0; s < SET_N; s++) begin
                for (int w = 0; w < WAY_N; w++) begin
                    if (!st_q.sets[s][w].glob) st_d.sets[s][w].valid = 1'b0;
                end
            end
        end else if (fill_en) begin
            st_d.sets[f_set][f_way].valid = 1'b1;
            st_d.sets[f_set][f_way].glob  = fill_global;
            st_d.sets[f_set][f_way].tag   = f_tag;
            st_d.sets[f_set][f_way].ppn   = fill_ppn;
            if (f_adv) st_d.rr[f_set] = f_way + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_va,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [PA_W-1:0]  lk_pa,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PPN_W-1:0] fill_ppn,
    input logic             flush
);
    // R3/R4: hit and miss never together
    a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R4: idle request gives quiet outputs
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss && lk_pa == '0));

    // R4: a miss drives a zero address
    a_r4_miss_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> lk_pa == '0);

    // R3: offset passes through untouched
    a_r3_hit_offset: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);

    // R5: a fill without flush is visible on the next cycle
    a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && $past(fill_en && !flush) && lk_va[VA_W-1:OFF_W] == $past(fill_vpn))
        |-> (lk_hit && lk_pa[PA_W-1:OFF_W] == $past(fill_ppn)));

    // R10: repeated lookup without updates is stable
    a_r10_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && $past(lk_req) && lk_va == $past(lk_va) && !$past(fill_en) && !$past(flush))
        |-> (lk_hit == $past(lk_hit) && lk_pa == $past(lk_pa)));
endmodule

bind vpn_xlate_tlb tlb_checker u_tlb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_va    (lk_va),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_pa    (lk_pa),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn),
    .flush    (flush)
);

// File: tb/vpn_xlate_tlb_bench.sv
`timescale 1ns/1ps
module vpn_xlate_tlb_bench;
    import tlb_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_req = 1'b0;
    logic [VA_W-1:0]  lk_va = '0;
    logic             fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_global = 1'b0;
    logic             flush = 1'b0;
    logic             lk_hit, lk_miss;
    logic [PA_W-1:0]  lk_pa;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vpn_xlate_tlb u_vpn_xlate_tlb (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_global(fill_global), .flush(flush)
    );

    // Reference model built from the requirements
    bit               m_val [SET_N][WAY_N];
    bit               m_glb [SET_N][WAY_N];
    logic [TAG_W-1:0] m_tag [SET_N][WAY_N];
    logic [PPN_W-1:0] m_ppn [SET_N][WAY_N];
    int               m_rr  [SET_N];

    function automatic logic [PA_W+1:0] exp_lookup(logic rq, logic [VA_W-1:0] va);
        int s = int'(va[OFF_W +: SET_W]);
        logic [TAG_W-1:0] t = va[VA_W-1 -: TAG_W];
        if (!rq) return '0;
        for (int w = 0; w < WAY_N; w++)
            if (m_val[s][w] && m_tag[s][w] == t)
                return {1'b1, 1'b0, m_ppn[s][w], va[OFF_W-1:0]};
        return {2'b01, {PA_W{1'b0}}};
    endfunction

    task automatic model_apply(logic fen, logic [VPN_W-1:0] fv, logic [PPN_W-1:0] fp,
                               logic fg, logic fl);
        int s = int'(fv[SET_W-1:0]);
        logic [TAG_W-1:0] t = fv[VPN_W-1:SET_W];
        int way = -1;
        if (fl) begin
            for (int i = 0; i < SET_N; i++)
                for (int w = 0; w < WAY_N; w++)
                    if (!m_glb[i][w]) m_val[i][w] = 0;
        end else if (fen) begin
            for (int w = 0; w < WAY_N; w++)
                if (m_val[s][w] && m_tag[s][w] == t) way = w;
            if (way < 0)
                for (int w = WAY_N-1; w >= 0; w--)
                    if (!m_val[s][w]) way = w;
            if (way < 0) begin
                way = m_rr[s];
                m_rr[s] = (m_rr[s] + 1) % WAY_N;
            end
            m_val[s][way] = 1; m_glb[s][way] = fg;
            m_tag[s][way] = t; m_ppn[s][way] = fp;
        end
    endtask

    task automatic check(string req, logic [PA_W+1:0] got, logic [PA_W+1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {hit,miss,pa} got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(string req, logic rq, logic [VA_W-1:0] va, logic fen,
                        logic [VPN_W-1:0] fv, logic [PPN_W-1:0] fp, logic fg, logic fl);
        lk_req = rq; lk_va = va; fill_en = fen; fill_vpn = fv;
        fill_ppn = fp; fill_global = fg; flush = fl;
        #1;
        check(req, {lk_hit, lk_miss, lk_pa}, exp_lookup(rq, va));
        @(posedge clk);
        model_apply(fen, fv, fp, fg, fl);
        @(negedge clk);
    endtask

    task automatic look(string req, logic [VA_W-1:0] va);
        step(req, 1'b1, va, 1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic fill(string req, logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic g);
        step(req, 1'b0, '0, 1'b1, v, p, g, 1'b0);
    endtask

    function automatic logic [VA_W-1:0] va_of(int t, int s, int o);
        return {TAG_W'(t), SET_W'(s), OFF_W'(o)};
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(int t, int s);
        return {TAG_W'(t), SET_W'(s)};
    endfunction

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < SET_N; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAY_N; w++) begin
                m_val[s][w] = 0; m_glb[s][w] = 0; m_tag[s][w] = '0; m_ppn[s][w] = '0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, every set misses
        for (int s = 0; s < SET_N; s++) look("R1", va_of(0, s, 5));
        // R4: idle request is quiet
        step("R4", 1'b0, 14'h03D4, 1'b0, '0, '0, 1'b0, 1'b0);

        // R3: worked example
        fill("R5", 8'h0F, 6'h0D, 1'b0);
        lk_req = 1'b1; lk_va = 14'h03D4; #1;
        check("R3", {lk_hit, lk_miss, lk_pa}, {2'b10, 12'h354});
        @(negedge clk);
        // R2: same tag in another set misses
        look("R2", 14'h0314);
        check("R2", {lk_hit, lk_miss, lk_pa}, {2'b01, 12'h000});
        // R10: repeated lookup
        look("R10", 14'h03D4);
        look("R10", 14'h03D4);

        // R7: fill set 1 past capacity
        for (int t = 1; t <= 4; t++) fill("R7", vpn_of(t, 1), 6'(t + 16), 1'b0);
        for (int t = 1; t <= 4; t++) look("R7", va_of(t, 1, t));
        fill("R7", vpn_of(5, 1), 6'h25, 1'b0);
        look("R7", va_of(1, 1, 0));
        check("R7", {lk_hit, lk_miss}, 2'b01);
        look("R7", va_of(5, 1, 9));
        fill("R7", vpn_of(6, 1), 6'h26, 1'b0);
        look("R7", va_of(2, 1, 0));
        look("R7", va_of(6, 1, 0));

        // R6: refill present page in place
        fill("R6", vpn_of(3, 1), 6'h3A, 1'b0);
        look("R6", va_of(3, 1, 1));
        look("R6", va_of(4, 1, 1));
        look("R6", va_of(5, 1, 1));

        // R8: flush keeps globals only
        fill("R8", vpn_of(16, 2), 6'h11, 1'b1);
        fill("R8", vpn_of(17, 2), 6'h12, 1'b0);
        step("R8", 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1);
        look("R8", va_of(16, 2, 3));
        check("R8", {lk_hit, lk_miss, lk_pa}, {2'b10, 6'h11, 6'h03});
        look("R8", va_of(17, 2, 3));
        look("R8", 14'h03D4);
        look("R8", va_of(5, 1, 0));

        // R9: flush and fill together, fill dropped
        step("R9", 1'b0, '0, 1'b1, vpn_of(20, 3), 6'h2F, 1'b1, 1'b1);
        look("R9", va_of(20, 3, 0));
        check("R9", {lk_hit, lk_miss}, 2'b01);

        // Seeded random traffic against the model
        for (int i = 0; i < 5000; i++) begin
            int r = int'($urandom % 100);
            logic [VA_W-1:0]  va = va_of(int'($urandom % 8), int'($urandom % SET_N), int'($urandom % 64));
            logic [VPN_W-1:0] fv = vpn_of(int'($urandom % 8), int'($urandom % SET_N));
            logic [PPN_W-1:0] fp = PPN_W'($urandom);
            logic             fg = ($urandom % 8) == 0;
            logic             rq = ($urandom % 8) != 0;
            if (r < 35)      step("R5", rq, va, 1'b1, fv, fp, fg, 1'b0);
            else if (r < 37) step("R8", rq, va, 1'b0, fv, fp, fg, 1'b1);
            else if (r < 38) step("R9", rq, va, 1'b1, fv, fp, fg, 1'b1);
            else             step("R2", rq, va, 1'b0, fv, fp, fg, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule